// File: doc/BRIEF.md
# Pin Polarity and Override Stage

This block sits between a group of key and status pins and everything that uses them. Inbound, each pin may be inverted before the internal logic sees it. Outbound, each pad driver takes the inbound value, replaces it with a software-forced level when that level is permitted, and then applies its own inversion. A write-protect lane belongs to the same group. Its pad never follows its pin. It rests asserted low and leaves that state only when software forces it.

Software reaches the configuration through a plain single-cycle write port and a combinational read port. It can also read a synchronized copy of the pins as they arrive, taken before any inversion. The pin paths have no registers. The only storage is the configuration registers and the two-stage capture of the raw pins.

Top module: `pin_polarity_ovr`

## Requirements
- R1: Out of reset every configuration register reads 0. Each key pad equals its key pin, and the write-protect pad `wp_l_o` is 0.
- R2: Each core output equals its pin XOR its input-inversion bit. Bit i (i < NUM_KEYS) is key i, and bit NUM_KEYS is the write-protect lane.
- R3: With no override active, key pad i equals pin i XOR input-inversion bit i XOR output-inversion bit i. If no inputs and no configuration change, the key pads hold their values.
- R4: A lane is forced to its override-value bit when its override-enable bit is 1 and the matching permit bit is 1. The matching permit bit is allow-1 for a value of 1 and allow-0 for a value of 0.
- R5: When override is enabled but the requested level is not permitted, the pad keeps its normal value.
- R6: Output inversion is applied after the override selection, so a forced level is also inverted.
- R7: The write-protect pad has no path from `wp_raw_i`. Its normal value is 0, and it changes only when the configuration changes.
- R8: Address 6 reads the raw pins `{wp_raw_i, key_raw_i}` before inversion. The value appears two clock edges after the pins change.
- R9: Addresses 0 to 5 are input inversion, output inversion, override enable, override value, allow-0 and allow-1. Each takes a write in one cycle and reads back what was written. A write to address 6 or 7 changes nothing, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Register address for read and write |
| cfg_wdata_i | input | NUM_KEYS+1 | Write data, one bit per lane |
| cfg_rdata_o | output | NUM_KEYS+1 | Read data for cfg_addr_i |
| key_raw_i | input | NUM_KEYS | Key pins as received |
| wp_raw_i | input | 1 | Write-protect pin as received |
| key_core_o | output | NUM_KEYS | Key values after input inversion |
| wp_core_o | output | 1 | Write-protect pin after input inversion |
| key_o | output | NUM_KEYS | Key pad drive |
| wp_l_o | output | 1 | Write-protect pad drive, active low |

## Verification
The vector table covers four kinds of pattern.
- Four patterns separate the cases where the two inversions cancel from the cases where only one side inverts.
- Full overrides with every level permitted show that forcing works.
- Partially permitted overrides leave some lanes on their passthrough value, which separates the allow-0 mask from the allow-1 mask.
- An inverted forced pattern shows that output inversion comes last.

Directed steps toggle the write-protect pin under a fixed configuration to expose any bypass. They also step the raw capture one edge at a time to pin its two-edge delay, and aim writes at the read-only and unmapped addresses.

// File: rtl/pin_polarity_pkg.sv
package pin_polarity_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_IN_INV   = 3'd0,
        ADDR_OUT_INV  = 3'd1,
        ADDR_OVR_EN   = 3'd2,
        ADDR_OVR_VAL  = 3'd3,
        ADDR_ALLOW0   = 3'd4,
        ADDR_ALLOW1   = 3'd5,
        ADDR_RAW_SNAP = 3'd6
    } cfg_addr_e;
endpackage

// File: rtl/ppo_sync.sv
module ppo_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign sync_o = sync_q.stage2;
endmodule

// File: rtl/ppo_regfile.sv
module ppo_regfile
    import pin_polarity_pkg::*;
#(
    parameter int LANES = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  wdata_i,
    input  logic [LANES-1:0]  snap_i,
    output logic [LANES-1:0]  rdata_o,
    output logic [LANES-1:0]  in_inv_o,
    output logic [LANES-1:0]  out_inv_o,
    output logic [LANES-1:0]  ovr_en_o,
    output logic [LANES-1:0]  ovr_val_o,
    output logic [LANES-1:0]  allow0_o,
    output logic [LANES-1:0]  allow1_o
);
    typedef struct packed {
        logic [LANES-1:0] in_inv;
        logic [LANES-1:0] out_inv;
        logic [LANES-1:0] ovr_en;
        logic [LANES-1:0] ovr_val;
        logic [LANES-1:0] allow0;
        logic [LANES-1:0] allow1;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (addr_i)
                ADDR_IN_INV:  cfg_d.in_inv  = wdata_i;
                ADDR_OUT_INV: cfg_d.out_inv = wdata_i;
                ADDR_OVR_EN:  cfg_d.ovr_en  = wdata_i;
                ADDR_OVR_VAL: cfg_d.ovr_val = wdata_i;
                ADDR_ALLOW0:  cfg_d.allow0  = wdata_i;
                ADDR_ALLOW1:  cfg_d.allow1  = wdata_i;
                default:      cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    always_comb begin
        case (addr_i)
            ADDR_IN_INV:   rdata_o = cfg_q.in_inv;
            ADDR_OUT_INV:  rdata_o = cfg_q.out_inv;
            ADDR_OVR_EN:   rdata_o = cfg_q.ovr_en;
            ADDR_OVR_VAL:  rdata_o = cfg_q.ovr_val;
            ADDR_ALLOW0:   rdata_o = cfg_q.allow0;
            ADDR_ALLOW1:   rdata_o = cfg_q.allow1;
            ADDR_RAW_SNAP: rdata_o = snap_i;
            default:       rdata_o = '0;
        endcase
    end

    assign in_inv_o  = cfg_q.in_inv;
    assign out_inv_o = cfg_q.out_inv;
    assign ovr_en_o  = cfg_q.ovr_en;
    assign ovr_val_o = cfg_q.ovr_val;
    assign allow0_o  = cfg_q.allow0;
    assign allow1_o  = cfg_q.allow1;
endmodule

// File: rtl/ppo_lane.sv
module ppo_lane #(
    parameter bit PASS_THRU = 1'b1
) (
    input  logic raw_i,
    input  logic in_inv_i,
    input  logic out_inv_i,
    input  logic ovr_en_i,
    input  logic ovr_val_i,
    input  logic allow0_i,
    input  logic allow1_i,
    output logic core_o,
    output logic pad_o
);
    logic normal_val;
    logic permit;
    logic pre_inv;

    always_comb begin
        core_o     = raw_i ^ in_inv_i;
        // lanes without a bypass rest at their asserted-low default
        normal_val = PASS_THRU ? core_o : 1'b0;
        permit     = ovr_val_i ? allow1_i : allow0_i;
        pre_inv    = (ovr_en_i && permit) ? ovr_val_i : normal_val;
        pad_o      = pre_inv ^ out_inv_i;
    end
endmodule

// File: rtl/pin_polarity_ovr.sv
module pin_polarity_ovr
    import pin_polarity_pkg::*;
#(
    parameter int NUM_KEYS = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cfg_we_i,
    input  logic [ADDR_W-1:0]   cfg_addr_i,
    input  logic [NUM_KEYS:0]   cfg_wdata_i,
    output logic [NUM_KEYS:0]   cfg_rdata_o,
    input  logic [NUM_KEYS-1:0] key_raw_i,
    input  logic                wp_raw_i,
    output logic [NUM_KEYS-1:0] key_core_o,
    output logic                wp_core_o,
    output logic [NUM_KEYS-1:0] key_o,
    output logic                wp_l_o
);
    localparam int LANES = NUM_KEYS + 1;
    localparam int WP_LANE = NUM_KEYS;

    logic [LANES-1:0] raw_all;
    logic [LANES-1:0] raw_snap;
    logic [LANES-1:0] core_all;
    logic [LANES-1:0] pad_all;
    logic [LANES-1:0] in_inv_q, out_inv_q, ovr_en_q, ovr_val_q, allow0_q, allow1_q;

    assign raw_all = {wp_raw_i, key_raw_i};

    ppo_sync #(.WIDTH(LANES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_all),
        .sync_o  (raw_snap)
    );

    ppo_regfile #(.LANES(LANES)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .snap_i    (raw_snap),
        .rdata_o   (cfg_rdata_o),
        .in_inv_o  (in_inv_q),
        .out_inv_o (out_inv_q),
        .ovr_en_o  (ovr_en_q),
        .ovr_val_o (ovr_val_q),
        .allow0_o  (allow0_q),
        .allow1_o  (allow1_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ppo_lane #(.PASS_THRU(g != WP_LANE)) u_lane (
            .raw_i     (raw_all[g]),
            .in_inv_i  (in_inv_q[g]),
            .out_inv_i (out_inv_q[g]),
            .ovr_en_i  (ovr_en_q[g]),
            .ovr_val_i (ovr_val_q[g]),
            .allow0_i  (allow0_q[g]),
            .allow1_i  (allow1_q[g]),
            .core_o    (core_all[g]),
            .pad_o     (pad_all[g])
        );
    end

    assign key_core_o = core_all[NUM_KEYS-1:0];
    assign wp_core_o  = core_all[WP_LANE];
    assign key_o      = pad_all[NUM_KEYS-1:0];
    assign wp_l_o     = pad_all[WP_LANE];
endmodule

// File: rtl/ppo_checker.sv
module ppo_checker #(
    parameter int NK = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          cfg_we_i,
    input logic [2:0]    cfg_addr_i,
    input logic [NK:0]   cfg_wdata_i,
    input logic [NK-1:0] key_raw_i,
    input logic          wp_raw_i,
    input logic [NK-1:0] key_o,
    input logic          wp_l_o,
    input logic [NK:0]   snap_i,
    input logic [NK:0]   in_inv_i,
    input logic [NK:0]   out_inv_i,
    input logic [NK:0]   ovr_en_i,
    input logic [NK:0]   ovr_val_i,
    input logic [NK:0]   allow0_i,
    input logic [NK:0]   allow1_i
);
    logic [1:0] age_q;
    logic       written_q;
    logic [6*(NK+1)-1:0] cfg_cat;

    assign cfg_cat = {in_inv_i, out_inv_i, ovr_en_i, ovr_val_i, allow0_i, allow1_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            age_q     <= '0;
            written_q <= 1'b0;
        end else begin
            if (age_q != 2'd2) age_q <= age_q + 2'd1;
            if (cfg_we_i) written_q <= 1'b1;
        end
    end

    // R1
    reset_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !written_q |-> (wp_l_o == 1'b0 && key_o == key_raw_i));

    // R3
    key_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($stable(cfg_cat) && $stable(key_raw_i)) |-> $stable(key_o));

    // R7
    wp_no_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(cfg_cat) |-> $stable(wp_l_o));

    // R8
    snap_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd2) |-> (snap_i == $past({wp_raw_i, key_raw_i}, 2)));

    // R9
    reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_addr_i == 3'd0) |=> (in_inv_i == $past(cfg_wdata_i)));
endmodule

bind pin_polarity_ovr ppo_checker #(.NK(NUM_KEYS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .key_raw_i   (key_raw_i),
    .wp_raw_i    (wp_raw_i),
    .key_o       (key_o),
    .wp_l_o      (wp_l_o),
    .snap_i      (raw_snap),
    .in_inv_i    (in_inv_q),
    .out_inv_i   (out_inv_q),
    .ovr_en_i    (ovr_en_q),
    .ovr_val_i   (ovr_val_q),
    .allow0_i    (allow0_q),
    .allow1_i    (allow1_q)
);

// File: tb/pin_polarity_ovr_tb_top.sv
module pin_polarity_ovr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NK = 4;
    localparam int L = NK + 1;
    localparam int NVEC = 9;

    typedef struct packed {
        logic [L-1:0] ii, oi, en, val, a0, a1, raw, exp_core, exp_out;
    } vec_t;

    // fields: in_inv, out_inv, ovr_en, ovr_val, allow0, allow1, raw, core, pads
    localparam vec_t VECS [NVEC] = '{
        '{5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b11010, 5'b11010, 5'b01010},
        '{5'b01111, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b10101, 5'b11010, 5'b01010},
        '{5'b01111, 5'b01111, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b10110, 5'b11001, 5'b00110},
        '{5'b00000, 5'b00011, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00011},
        '{5'b00000, 5'b00000, 5'b11111, 5'b10101, 5'b11111, 5'b11111, 5'b01010, 5'b01010, 5'b10101},
        '{5'b00000, 5'b00000, 5'b11111, 5'b10101, 5'b00000, 5'b10001, 5'b01010, 5'b01010, 5'b11011},
        '{5'b00100, 5'b10010, 5'b00011, 5'b00001, 5'b00010, 5'b00001, 5'b00110, 5'b00010, 5'b10011},
        '{5'b00000, 5'b10000, 5'b11111, 5'b00000, 5'b00000, 5'b00000, 5'b11111, 5'b11111, 5'b11111},
        '{5'b00000, 5'b00000, 5'b10000, 5'b10000, 5'b00000, 5'b10000, 5'b00000, 5'b00000, 5'b10000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic [2:0]    addr = '0;
    logic [L-1:0]  wdata = '0;
    logic [L-1:0]  rdata;
    logic [NK-1:0] key_raw = '0;
    logic          wp_raw = 1'b0;
    logic [NK-1:0] key_core, key_pad;
    logic          wp_core, wp_pad;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_polarity_ovr #(.NUM_KEYS(NK)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (we),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata),
        .key_raw_i   (key_raw),
        .wp_raw_i    (wp_raw),
        .key_core_o  (key_core),
        .wp_core_o   (wp_core),
        .key_o       (key_pad),
        .wp_l_o      (wp_pad)
    );

    task automatic check(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [L-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [L-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_raw(input logic [L-1:0] r);
        @(negedge clk);
        {wp_raw, key_raw} = r;
    endtask

    initial begin
        logic [L-1:0] rv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        set_raw(5'b10110);
        #1;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), rv);
            check("R1 reg reset", rv, '0);
        end
        check("R1 pads after reset", {wp_pad, key_pad}, 5'b00110);

        // vector table: R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            wr(3'd0, VECS[i].ii);
            wr(3'd1, VECS[i].oi);
            wr(3'd2, VECS[i].en);
            wr(3'd3, VECS[i].val);
            wr(3'd4, VECS[i].a0);
            wr(3'd5, VECS[i].a1);
            set_raw(VECS[i].raw);
            #1;
            check($sformatf("R2 core vec%0d", i), {wp_core, key_core}, VECS[i].exp_core);
            check($sformatf("R3/R4/R5/R6 pads vec%0d", i), {wp_pad, key_pad}, VECS[i].exp_out);
        end

        // R7: toggling the write-protect pin under fixed configuration
        wr(3'd2, 5'b00000);
        wr(3'd1, 5'b00000);
        set_raw(5'b00000);
        #1;
        check("R7 wp idle low", {4'b0, wp_pad}, 5'b00000);
        set_raw(5'b10000);
        #1;
        check("R7 wp pin high no bypass", {4'b0, wp_pad}, 5'b00000);
        wr(3'd0, 5'b10000);
        #1;
        check("R7 wp inverted pin no bypass", {4'b0, wp_pad}, 5'b00000);

        // R8: raw capture, pre-inversion, two-edge delay
        wr(3'd0, 5'b11111);
        set_raw(5'b01001);
        @(posedge clk); @(posedge clk); #1;
        rd(3'd6, rv);
        check("R8 raw before inversion", rv, 5'b01001);
        set_raw(5'b10110);
        @(posedge clk); #1;
        rd(3'd6, rv);
        check("R8 one edge still old", rv, 5'b01001);
        @(posedge clk); #1;
        rd(3'd6, rv);
        check("R8 two edges new", rv, 5'b10110);

        // R9: readback and ignored addresses
        wr(3'd4, 5'b10011);
        rd(3'd4, rv);
        check("R9 allow0 readback", rv, 5'b10011);
        wr(3'd6, 5'b00000);
        rd(3'd6, rv);
        check("R9 write to raw ignored", rv, 5'b10110);
        wr(3'd7, 5'b11111);
        rd(3'd7, rv);
        check("R9 unmapped reads zero", rv, 5'b00000);
        rd(3'd4, rv);
        check("R9 unmapped write no effect", rv, 5'b10011);
        rd(3'd0, rv);
        check("R9 in_inv kept", rv, 5'b11111);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule